// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a cycle-accurate, synthesizable model of one synchronous pipelined SRAM array. Its data bus carries a steady stream of reads and writes in any mix with no idle cycle at a direction change. Reads and writes pass through the same two-stage pipeline. Read data appears on the shared bus in the same cycle slot in which a write's data is expected. A write command therefore takes its data two enabled edges after the command edge, which is the same distance a read needs to return its word.

Each operation is started by a load edge, which takes the external address. Advance edges that follow step through a four-beat burst, in either linear or XOR order, wrapping inside an aligned group of four words. Four active-low byte enables mask writes. A write that selects no byte leaves memory untouched. An active-low clock enable freezes every register. An output enable gates only the tri-state driver. A sleep input puts the array into a quiet state two cycles after it rises and returns it to service two cycles after it falls. A read issued right behind a write to the same word returns the merged new data.

Top module: `pipeburst_sram`

## Requirements
- R1: On an enabled edge with `load_n` low and the chip selected, `wr_n` high starts a read and `wr_n` low starts a write at `addr`. With the chip not selected, the edge starts a deselect: memory is unchanged and the bus stays undriven.
- R2: On an enabled edge with `load_n` high, the previous operation continues at the next burst address. A continue after a deselect stays a deselect.
- R3: For a read taken at enabled edge n, the word is on `dq` from enabled edge n+1 until the next enabled edge. It is driven only while `oe_n` is low, and the driver releases in the same cycle that `oe_n` goes high.
- R4: For a write taken at enabled edge n, the data is sampled from `dq` at enabled edge n+2.
- R5: `be_n[i]` low writes byte i (`dq[8i+7:8i]`). A write with `be_n` = 4'b1111 changes no memory.
- R6: While `clk_en_n` is high, every input except `oe_n` and `sleep` is ignored, and all pipeline and burst state holds. A pending read keeps its word on the bus. A pending write waits for the next enabled edge and takes the bus value present at that edge.
- R7: Beat k (k = 0..3, repeating) of a burst starting at address S keeps the upper bits of S. Its two low bits are (S+k) mod 4 when `order_xor` = 0 and S XOR k when `order_xor` = 1.
- R8: The chip is selected only when `sel_a_n` = 0, `sel_b_n` = 0 and `sel_c` = 1.
- R9: If `sleep` is first seen high at edge n, commands are still taken at edges up to n+1. From edge n+2 onward the array ignores commands, drops pending operations, leaves the bus undriven and keeps its contents. If `sleep` is first seen low at edge m, commands are taken again from edge m+2, and a continue at that point is a deselect.
- R10: A read whose array access coincides with the data edge of a write to the same word returns the byte-merged written data.
- R11: The block never drives `dq` during a write's data phase or while no read occupies the output stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| load_n | input | 1 | Low loads a new operation, high continues the burst |
| addr | input | AW | Word address |
| wr_n | input | 1 | Low selects write, high selects read |
| be_n | input | DW/8 | Active-low byte write enables |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Second active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| oe_n | input | 1 | Active-low output enable (combinational) |
| order_xor | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Sleep request, active high |
| dq | inout | DW | Shared bidirectional data bus |

## Verification
A wrong burst counter or stage register shows as a wrong word on `dq` two enabled edges after the faulty edge. A write that commits in the wrong slot shows up on the next read of that word. A driver that fires in a write slot, an idle slot, an `oe_n`-high slot or a sleeping cycle corrupts the bench's own probe value on the bus in that same cycle. So contention is caught at once rather than after a later read. Errors in freeze and sleep timing move a command by one edge, and the next data slot or read-back exposes the move.

// File: rtl/pipeburst_sram_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the pipelined burst SRAM.
// Assumes bursts are four beats long and wrap inside an aligned group of four.
package pipeburst_sram_pkg;
    localparam int BEAT_BITS = 2;

    // Low address bits of a burst beat, in linear or XOR order.
    function automatic logic [BEAT_BITS-1:0] beat_lo(
        input logic [BEAT_BITS-1:0] start,
        input logic [BEAT_BITS-1:0] beat,
        input logic                 interleave
    );
        return interleave ? (start ^ beat) : (start + beat);
    endfunction
endpackage

// File: rtl/pipeburst_sleep_seq.sv
`timescale 1ns/1ps
// Two-stage sleep request sequencer.
// asleep rises two edges after sleep is first seen high and falls two
// edges after it is first seen low. It runs whatever the clock enable is.
module pipeburst_sleep_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_in,
    output logic asleep
);
    logic req_q;

    // Shift the request through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            asleep <= 1'b0;
        end else begin
            req_q  <= sleep_in;
            asleep <= req_q;
        end
    end

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> asleep); // R9
    AST_WAKE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_q && !sleep_in) |=> !asleep); // R9
endmodule

// File: rtl/pipeburst_burst_gen.sv
`timescale 1ns/1ps
// Burst sequencer: holds the operation type, base address and beat count
// of the current burst, and offers the operation for the next enabled edge.
// Assumes AW >= 2. The outputs are only meaningful when step is high.
module pipeburst_burst_gen
    import pipeburst_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          flush,
    input  logic          load_n,
    input  logic          chip_sel,
    input  logic          wr_n,
    input  logic [AW-1:0] addr_in,
    input  logic          interleave,
    output logic          nxt_valid,
    output logic          nxt_wr,
    output logic [AW-1:0] nxt_addr
);
    logic                 op_valid;
    logic                 op_wr;
    logic [AW-1:0]        base;
    logic [BEAT_BITS-1:0] beat;
    logic [BEAT_BITS-1:0] beat_nx;

    assign beat_nx = beat + 1'b1;

    // Burst state: load on a load edge, count on an advance edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_wr    <= 1'b0;
            base     <= '0;
            beat     <= '0;
        end else if (flush) begin
            op_valid <= 1'b0;
        end else if (step && !load_n) begin
            op_valid <= chip_sel;
            op_wr    <= !wr_n;
            base     <= addr_in;
            beat     <= '0;
        end else if (step && op_valid) begin
            beat     <= beat_nx;
        end
    end

    // Operation offered to stage A on this edge.
    always_comb begin
        if (!load_n) begin
            nxt_valid = chip_sel;
            nxt_wr    = !wr_n;
            nxt_addr  = addr_in;
        end else begin
            nxt_valid = op_valid;
            nxt_wr    = op_wr;
            nxt_addr  = {base[AW-1:BEAT_BITS], beat_lo(base[BEAT_BITS-1:0], beat_nx, interleave)};
        end
    end

    AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !flush && load_n && op_valid && beat == 2'd3) |=> beat == 2'd0); // R7
    AST_DESEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !op_valid) |=> !op_valid); // R2
endmodule

// File: rtl/pipeburst_store.sv
`timescale 1ns/1ps
// Byte-writable storage array with a registered read port.
// A write and a read to the same word on the same edge forward the
// written bytes into the read register. The array is not reset.
module pipeburst_store #(
    parameter int DEPTH = 256,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int NB   = DW / 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [NB-1:0] wr_be_n,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_merged;
    logic          fwd_hit;

    assign fwd_hit = wr_en && (wr_addr == rd_addr);

    for (genvar b = 0; b < NB; b++) begin : g_byte
        // Byte lane write into the array.
        always_ff @(posedge clk) begin
            if (wr_en && !wr_be_n[b]) begin
                mem[wr_addr][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
        // Byte lane of the forwarded read word.
        assign rd_merged[8*b +: 8] = (fwd_hit && !wr_be_n[b]) ? wr_data[8*b +: 8]
                                                               : mem[rd_addr][8*b +: 8];
    end

    // Output register, loaded when a read moves to the output stage.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= rd_merged;
        end
    end
endmodule

// File: rtl/pipeburst_sram.sv
`timescale 1ns/1ps
// Zero-turnaround pipelined burst SRAM, one array.
// Stage A holds the operation taken at an edge. Stage B is the bus slot:
// a read drives its registered word there, and a write takes its data there.
// Assumes DW is a multiple of 8 and DEPTH is a power of two of at least 4.
module pipeburst_sram #(
    parameter int DEPTH = 256,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int NB   = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en_n,
    input  logic          load_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_n,
    input  logic [NB-1:0] be_n,
    input  logic          sel_a_n,
    input  logic          sel_b_n,
    input  logic          sel_c,
    input  logic          oe_n,
    input  logic          order_xor,
    input  logic          sleep,
    inout  wire  [DW-1:0] dq
);
    logic          asleep;
    logic          step;
    logic          chip_sel;
    logic          nxt_valid;
    logic          nxt_wr;
    logic [AW-1:0] nxt_addr;
    logic          a_valid, a_wr;
    logic [AW-1:0] a_addr;
    logic [NB-1:0] a_be_n;
    logic          b_valid, b_wr;
    logic [AW-1:0] b_addr;
    logic [NB-1:0] b_be_n;
    logic [DW-1:0] rd_word;
    logic          bus_drive;

    assign step     = !clk_en_n && !asleep;
    assign chip_sel = !sel_a_n && !sel_b_n && sel_c;

    pipeburst_sleep_seq u_sleep (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_in (sleep),
        .asleep   (asleep)
    );

    pipeburst_burst_gen #(.AW(AW)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .flush      (asleep),
        .load_n     (load_n),
        .chip_sel   (chip_sel),
        .wr_n       (wr_n),
        .addr_in    (addr),
        .interleave (order_xor),
        .nxt_valid  (nxt_valid),
        .nxt_wr     (nxt_wr),
        .nxt_addr   (nxt_addr)
    );

    // Two-stage operation pipeline: flushed while asleep, frozen when not stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_wr    <= 1'b0;
            a_addr  <= '0;
            a_be_n  <= '1;
            b_valid <= 1'b0;
            b_wr    <= 1'b0;
            b_addr  <= '0;
            b_be_n  <= '1;
        end else if (asleep) begin
            a_valid <= 1'b0;
            b_valid <= 1'b0;
        end else if (step) begin
            a_valid <= nxt_valid;
            a_wr    <= nxt_wr;
            a_addr  <= nxt_addr;
            a_be_n  <= be_n;
            b_valid <= a_valid;
            b_wr    <= a_wr;
            b_addr  <= a_addr;
            b_be_n  <= a_be_n;
        end
    end

    pipeburst_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .wr_en   (step && b_valid && b_wr),
        .wr_addr (b_addr),
        .wr_be_n (b_be_n),
        .wr_data (dq),
        .rd_en   (step && a_valid && !a_wr),
        .rd_addr (a_addr),
        .rd_data (rd_word)
    );

    assign bus_drive = b_valid && !b_wr && !oe_n && !asleep;
    assign dq        = bus_drive ? rd_word : {DW{1'bz}};

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n && !asleep) |=> ($stable(b_valid) && $stable(b_addr) && $stable(a_valid) && $stable(a_addr))); // R6
    AST_SLEEP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> (!a_valid && !b_valid)); // R9
    AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (step && a_valid) |=> b_valid); // R11
endmodule

// File: tb/pipeburst_sram_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a cycle model of the requirements drives expected
// bus values; the bench probes the bus whenever the block must be silent.
module pipeburst_sram_tb;
    localparam int DEPTH = 256;
    localparam int DW    = 32;
    localparam int AW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          clk_en_n = 1'b0, load_n = 1'b1, wr_n = 1'b1;
    logic          sel_a_n = 1'b0, sel_b_n = 1'b0, sel_c = 1'b1;
    logic          oe_n = 1'b0, order_xor = 1'b0, sleep = 1'b0;
    logic [3:0]    be_n = 4'h0;
    logic [AW-1:0] addr = '0;
    logic          tb_drv = 1'b0;
    logic [DW-1:0] tb_val = '0;
    wire  [DW-1:0] dq;

    assign dq = tb_drv ? tb_val : {DW{1'bz}};

    pipeburst_sram #(.DEPTH(DEPTH), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
        .addr(addr), .wr_n(wr_n), .be_n(be_n), .sel_a_n(sel_a_n),
        .sel_b_n(sel_b_n), .sel_c(sel_c), .oe_n(oe_n), .order_xor(order_xor),
        .sleep(sleep), .dq(dq)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";

    logic [DW-1:0] ref_mem [DEPTH];
    logic          m_a_v = 0, m_a_wr = 0, m_b_v = 0, m_b_wr = 0;
    logic [AW-1:0] m_a_addr = '0, m_b_addr = '0, m_base = '0;
    logic [3:0]    m_a_be = '1, m_b_be = '1;
    logic          m_op_v = 0, m_op_wr = 0, m_sl1 = 0, m_sl2 = 0;
    logic [1:0]    m_beat = '0;

    function automatic logic [1:0] lo_of(input logic [1:0] s, input logic [1:0] k, input logic x);
        return x ? (s ^ k) : (s + k);
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock cycle: set bus, check, then advance the model at the edge.
    task automatic cycle();
        logic [DW-1:0] exp_v;
        logic          expect_read;
        expect_read = m_b_v && !m_b_wr && !oe_n && !m_sl2 && rst_n;
        if (expect_read) begin
            tb_drv = 1'b0;
            exp_v  = ref_mem[m_b_addr];
        end else begin
            tb_drv = 1'b1;
            tb_val = $urandom;
            exp_v  = tb_val;
        end
        #1;
        if (expect_read)          check(cur_tag, dq, exp_v);
        else if (m_b_v && m_b_wr) check("R11", dq, exp_v);
        else if (m_sl2)           check("R9", dq, exp_v);
        else                      check(cur_tag, dq, exp_v);
        @(posedge clk);
        if (!rst_n) begin
            m_a_v = 0; m_b_v = 0; m_op_v = 0; m_beat = 0; m_base = '0; m_sl1 = 0; m_sl2 = 0;
        end else begin
            if (m_sl2) begin
                m_a_v = 0; m_b_v = 0; m_op_v = 0;
            end else if (!clk_en_n) begin
                if (m_b_v && m_b_wr)
                    for (int b = 0; b < 4; b++)
                        if (!m_b_be[b]) ref_mem[m_b_addr][8*b +: 8] = tb_val[8*b +: 8];
                m_b_v = m_a_v; m_b_wr = m_a_wr; m_b_addr = m_a_addr; m_b_be = m_a_be;
                if (!load_n) begin
                    m_a_v = !sel_a_n && !sel_b_n && sel_c;
                    m_a_wr = !wr_n; m_a_addr = addr;
                    m_op_v = m_a_v; m_op_wr = !wr_n; m_base = addr; m_beat = 0;
                end else begin
                    m_a_v = m_op_v; m_a_wr = m_op_wr;
                    m_a_addr = {m_base[AW-1:2], lo_of(m_base[1:0], m_beat + 2'd1, order_xor)};
                    if (m_op_v) m_beat = m_beat + 2'd1;
                end
                m_a_be = be_n;
            end
            m_sl2 = m_sl1; m_sl1 = sleep;
        end
        @(negedge clk);
    endtask

    task automatic op(input bit ld, input bit wr, input logic [AW-1:0] a, input logic [3:0] be);
        clk_en_n = 1'b0; load_n = !ld; wr_n = !wr; addr = a; be_n = be;
        cycle();
    endtask

    task automatic idle();
        sel_a_n = 1'b1;
        op(1'b1, 1'b0, '0, 4'hF);
        sel_a_n = 1'b0;
    endtask

    task automatic burst(input bit wr, input logic [AW-1:0] a, input int beats);
        op(1'b1, wr, a, 4'h0);
        for (int i = 1; i < beats; i++) op(1'b0, wr, '0, 4'h0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL R1 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        cur_tag = "R1";
        for (int i = 0; i < 3; i++) cycle();
        rst_n = 1'b1;
        idle(); idle();

        // R4: fill memory with linear write bursts
        cur_tag = "R4";
        for (int i = 0; i < DEPTH / 4; i++) burst(1'b1, AW'(i * 4), 4);
        idle(); idle();

        // R7: both orders, every start offset, plus a run past the wrap
        cur_tag = "R7";
        for (int x = 0; x < 2; x++) begin
            order_xor = x[0];
            for (int s = 0; s < 4; s++) burst(1'b0, AW'(8'h40 + s), 4);
            burst(1'b0, 8'h52, 9);
            idle(); idle();
        end
        order_xor = 1'b0;

        // R1: back-to-back mixed read and write commands
        cur_tag = "R1";
        op(1'b1, 1'b1, 8'h10, 4'h0); op(1'b1, 1'b0, 8'h11, 4'h0);
        op(1'b1, 1'b1, 8'h12, 4'h0); op(1'b1, 1'b0, 8'h10, 4'h0);
        op(1'b1, 1'b0, 8'h12, 4'h0); idle(); idle();

        // R3: output enable toggled across consecutive read slots
        cur_tag = "R3";
        for (int i = 0; i < 8; i++) begin
            oe_n = i[0];
            op(1'b1, 1'b0, AW'(8'h20 + i), 4'h0);
        end
        oe_n = 1'b0; idle(); idle();

        // R5: byte masks and the all-masked abort
        cur_tag = "R5";
        op(1'b1, 1'b1, 8'h80, 4'b1110); op(1'b1, 1'b1, 8'h81, 4'b1101);
        op(1'b1, 1'b1, 8'h82, 4'b1011); op(1'b1, 1'b1, 8'h83, 4'b0111);
        op(1'b1, 1'b1, 8'h84, 4'b1111); op(1'b1, 1'b1, 8'h85, 4'b1010);
        idle(); idle();
        for (int i = 0; i < 6; i++) op(1'b1, 1'b0, AW'(8'h80 + i), 4'h0);
        idle(); idle();

        // R8: each select inactive turns a write into a deselect
        cur_tag = "R8";
        sel_a_n = 1'b1; op(1'b1, 1'b1, 8'h90, 4'h0); sel_a_n = 1'b0;
        sel_b_n = 1'b1; op(1'b1, 1'b1, 8'h91, 4'h0); sel_b_n = 1'b0;
        sel_c   = 1'b0; op(1'b1, 1'b1, 8'h92, 4'h0); sel_c   = 1'b1;
        idle(); idle();
        for (int i = 0; i < 3; i++) op(1'b1, 1'b0, AW'(8'h90 + i), 4'h0);
        idle(); idle();

        // R2: continues after a deselect stay deselected
        cur_tag = "R2";
        idle();
        for (int i = 0; i < 4; i++) op(1'b0, 1'b1, 8'h95, 4'h0);
        op(1'b1, 1'b0, 8'h95, 4'h0); idle(); idle();

        // R6: freeze in the middle of read and write bursts
        cur_tag = "R6";
        op(1'b1, 1'b0, 8'hA0, 4'h0); op(1'b0, 1'b0, '0, 4'h0);
        clk_en_n = 1'b1; load_n = 1'b0; wr_n = 1'b0; addr = 8'hA8; cycle(); cycle();
        op(1'b0, 1'b0, '0, 4'h0); op(1'b0, 1'b0, '0, 4'h0);
        op(1'b1, 1'b1, 8'hA4, 4'h0); op(1'b0, 1'b1, '0, 4'h3);
        clk_en_n = 1'b1; load_n = 1'b0; wr_n = 1'b1; addr = 8'hA9; cycle(); cycle(); cycle();
        op(1'b0, 1'b1, '0, 4'h0); op(1'b0, 1'b1, '0, 4'h0);
        idle(); idle(); burst(1'b0, 8'hA4, 4); burst(1'b0, 8'hA8, 4); idle(); idle();

        // R10: read right behind a write to the same word
        cur_tag = "R10";
        op(1'b1, 1'b1, 8'hB0, 4'b0101); op(1'b1, 1'b0, 8'hB0, 4'h0);
        op(1'b1, 1'b1, 8'hB1, 4'h0); idle(); op(1'b1, 1'b0, 8'hB1, 4'h0);
        burst(1'b1, 8'hB4, 4); burst(1'b0, 8'hB4, 4); idle(); idle();

        // R9: commands across sleep entry, sleep, and wake
        cur_tag = "R9";
        sleep = 1'b1;
        for (int i = 0; i < 6; i++) op(1'b1, 1'b1, AW'(8'hC0 + i), 4'h0);
        sleep = 1'b0;
        op(1'b1, 1'b1, 8'hC6, 4'h0);
        for (int i = 0; i < 3; i++) op(1'b0, 1'b1, '0, 4'h0);
        op(1'b1, 1'b1, 8'hC8, 4'h0); idle(); idle();
        for (int i = 0; i < 10; i++) op(1'b1, 1'b0, AW'(8'hC0 + i), 4'h0);
        idle(); idle();

        // Constrained random mix, forwarding-heavy address range
        cur_tag = "R10";
        for (int i = 0; i < 4000; i++) begin
            int r;
            if (i % 250 == 0) order_xor = 1'($urandom % 2);
            r = int'($urandom % 12);
            sel_a_n = (r == 0); sel_b_n = (r == 1); sel_c = (r != 2);
            oe_n = (($urandom % 10) == 0);
            clk_en_n = (($urandom % 10) == 0);
            load_n = (($urandom % 5) < 2);
            wr_n = 1'($urandom % 2);
            addr = AW'($urandom % 32);
            be_n = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
            cycle();
        end
        sel_a_n = 1'b0; sel_b_n = 1'b0; sel_c = 1'b1; oe_n = 1'b0; order_xor = 1'b0;
        idle(); idle();

        // R4: full read-back against the reference
        cur_tag = "R4";
        for (int i = 0; i < DEPTH / 4; i++) burst(1'b0, AW'(i * 4), 4);
        idle(); idle(); idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule